// File: doc/BRIEF.md
# External Line Interrupt Controller

The block collects 28 asynchronous external request lines, numbered 0 to 27, and turns them into four combined interrupt requests for a downstream interrupt controller. Each line is brought into the clock domain through a two-flop synchronizer. It is then checked against a trigger condition chosen per pair of lines: low level, high level, falling edge, rising edge or both edges. A qualifying condition sets a sticky pending bit for that line.

Software reaches the block over a small word-addressed register bus. Reads are combinational: the data comes back in the same cycle the read strobe is high. Writes take effect at the next clock edge. Pending bits latch whether or not a line is masked. The mask gates only the four combined outputs. Those outputs cover unequal ranges of lines: 0–3, 4–11, 12–19 and 20–27. Software clears a pending bit by writing a one to its position. It can read a status register that shows only the unmasked pending bits.

Top module: `ext_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets. Pending (offset 3) reads 0, mask (offset 2) reads 0x0FFFFFFF with every line blocked, both trigger registers (offsets 0 and 1) read 0, and `grp_irq` is 0.
- R2: A change on `line_in[n]` can set pending bit n no earlier than the third rising clock edge after the change. Two edges are spent in the synchronizer and one in the pending register.
- R3: Each line's 3-bit trigger code selects the mode: 000 is low level, 001 is high level, 01x is falling edge, 10x is rising edge and 11x is both edges. The pending bit sets on the cycle the synchronized input meets the condition.
- R4: Lines 2k and 2k+1 share one trigger field. Lines 0–15 use the register at offset 0 and lines 16–27 use the register at offset 1. The field sits at bits [(k mod 8)*4 +: 3].
- R5: Mask bit n (offset 2) set to 1 blocks line n from its group output, but pending bit n still latches events while masked.
- R6: Writing a word to pending (offset 3) clears exactly the bits written as one. Every other pending bit keeps its value.
- R7: A pending bit whose line meets its condition in the same cycle that a clear is written stays set. A level that is still active sets the bit again after a clear.
- R8: `grp_irq[0]` covers lines 0–3, `grp_irq[1]` lines 4–11, `grp_irq[2]` lines 12–19 and `grp_irq[3]` lines 20–27. Each output is high when any pending bit in its range is set with its mask bit clear.
- R9: Reading offset 4 returns pending AND NOT mask over bits 27:0, with zeros above.
- R10: Only bits 0–2 of each nibble of the trigger registers are stored. The register at offset 1 holds no fields above bit 23, so it reads at most 0x00777777. Offsets 5 to 7 read 0, and a read with `bus_rd` low returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 28 | Asynchronous external request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| grp_irq | output | 4 | Combined interrupt request per line group |

## Verification
The assertions check four things on every cycle. A pending bit only falls when a one was written to it. A detected event always leaves its pending bit set. Each group output equals the unmasked pending bits in its range, and the status read and the unused configuration bits match their rules. Other behaviour shows only in the bench scenarios, which compare a behavioural model every clock: the three-edge latency, the decode of each trigger code, the placement of a shared field for a line pair, and level re-triggering after a clear.

// File: rtl/ext_irq_pkg.sv
// Shared constants, register offsets, trigger decode and group range helpers
// for the external line interrupt controller.
// Assumes the first group is narrower than the others, and that every
// configuration register serves a fixed number of lines.
package ext_irq_pkg;

    localparam int LEAD_W        = 4;
    localparam int GRP_W         = 8;
    localparam int NUM_GRP       = 4;
    localparam int NUM_LINES     = LEAD_W + GRP_W * (NUM_GRP - 1);
    localparam int DATA_W        = 32;
    localparam int ADDR_W        = 3;
    localparam int FIELD_W       = 3;
    localparam int FIELD_STRIDE  = 4;
    localparam int LINES_PER_CFG = 16;
    localparam int NUM_CFG       = (NUM_LINES + LINES_PER_CFG - 1) / LINES_PER_CFG;
    localparam int SYNC_STAGES   = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CFG_LO = 3'd0,
        A_CFG_HI = 3'd1,
        A_MASK   = 3'd2,
        A_PEND   = 3'd3,
        A_STAT   = 3'd4
    } reg_addr_e;

    typedef enum logic [2:0] {
        TRG_LOW,
        TRG_HIGH,
        TRG_FALL,
        TRG_RISE,
        TRG_BOTH
    } trig_e;

    // Map a 3-bit trigger code to its mode.
    function automatic trig_e trig_of(input logic [FIELD_W-1:0] code);
        trig_e t;
        casez (code)
            3'b000:  t = TRG_LOW;
            3'b001:  t = TRG_HIGH;
            3'b01?:  t = TRG_FALL;
            3'b10?:  t = TRG_RISE;
            default: t = TRG_BOTH;
        endcase
        return t;
    endfunction

    // Lowest line number of group g.
    function automatic int grp_lo(input int g);
        return (g == 0) ? 0 : LEAD_W + GRP_W * (g - 1);
    endfunction

    // Highest line number of group g.
    function automatic int grp_hi(input int g);
        return LEAD_W + GRP_W * g - 1;
    endfunction

    // Bit offset of the trigger field used by line n inside its register.
    function automatic int field_lsb(input int n);
        return ((n % LINES_PER_CFG) / 2) * FIELD_STRIDE;
    endfunction

    // Storable bits of configuration register r.
    function automatic logic [DATA_W-1:0] cfg_keep(input int r);
        logic [DATA_W-1:0] k;
        k = '0;
        for (int n = 0; n < NUM_LINES; n++) begin
            if (n / LINES_PER_CFG == r) begin
                for (int b = 0; b < FIELD_W; b++) begin
                    k[field_lsb(n) + b] = 1'b1;
                end
            end
        end
        return k;
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
// Multi-stage synchronizer for a vector of asynchronous lines.
// Assumes each line is slow enough that single-bit synchronization is
// sufficient; the bits are not coherent with one another.
module ext_irq_sync #(
    parameter int W      = 28,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    // Shift the raw lines through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/ext_irq_detect.sv
// Per-line trigger detector: compares each synchronized level with its value
// from the previous cycle and flags an event according to the line's code.
// Assumes lvl is already in the clock domain.
module ext_irq_detect
    import ext_irq_pkg::*;
#(
    parameter int W = 28
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [W-1:0]              lvl,
    input  logic [W-1:0][FIELD_W-1:0] mode,
    output logic [W-1:0]              evt
);

    logic [W-1:0] prev_q;

    // Remember last cycle's synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    for (genvar n = 0; n < W; n++) begin : g_line
        // Decide whether this line meets its trigger condition this cycle.
        always_comb begin
            unique case (trig_of(mode[n]))
                TRG_LOW:  evt[n] = !lvl[n];
                TRG_HIGH: evt[n] = lvl[n];
                TRG_FALL: evt[n] = !lvl[n] && prev_q[n];
                TRG_RISE: evt[n] = lvl[n] && !prev_q[n];
                default:  evt[n] = lvl[n] ^ prev_q[n];
            endcase
        end
    end

endmodule

// File: rtl/ext_irq_group.sv
// Merges unmasked pending bits into one request per group of lines.
// Assumes the group ranges given by the package helpers tile all lines.
module ext_irq_group
    import ext_irq_pkg::*;
(
    input  logic [NUM_LINES-1:0] pend,
    input  logic [NUM_LINES-1:0] mask,
    output logic [NUM_GRP-1:0]   grp_irq
);

    logic [NUM_LINES-1:0] live;

    assign live = pend & ~mask;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int LO = grp_lo(g);
        localparam int HI = grp_hi(g);
        assign grp_irq[g] = |live[HI:LO];
    end

endmodule

// File: rtl/ext_irq_regs.sv
// Register file: trigger configuration, mask and write-one-to-clear pending,
// plus the combinational read mux and the per-line trigger code fan-out.
// Assumes single-cycle bus strobes; a detected event beats a clear.
module ext_irq_regs
    import ext_irq_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_wr,
    input  logic                              bus_rd,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    input  logic [NUM_LINES-1:0]              evt,
    output logic [DATA_W-1:0]                 bus_rdata,
    output logic [NUM_LINES-1:0][FIELD_W-1:0] line_mode,
    output logic [NUM_LINES-1:0]              pend,
    output logic [NUM_LINES-1:0]              mask
);

    localparam int PAD_W = DATA_W - NUM_LINES;

    logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;
    logic [NUM_LINES-1:0]           pend_q;
    logic [NUM_LINES-1:0]           mask_q;
    logic [NUM_LINES-1:0]           clr;

    for (genvar r = 0; r < NUM_CFG; r++) begin : g_cfg
        localparam logic [DATA_W-1:0] KEEP = cfg_keep(r);
        // Store the writable trigger bits of configuration register r.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[r] <= '0;
            else if (bus_wr && bus_addr == ADDR_W'(r))
                cfg_q[r] <= bus_wdata & KEEP;
        end
    end

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_mode
        localparam int R  = n / LINES_PER_CFG;
        localparam int SH = field_lsb(n);
        assign line_mode[n] = cfg_q[R][SH +: FIELD_W];
    end

    // Hold the per-line mask; all lines start blocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (bus_wr && bus_addr == A_MASK)
            mask_q <= bus_wdata[NUM_LINES-1:0];
    end

    assign clr = (bus_wr && bus_addr == A_PEND) ? bus_wdata[NUM_LINES-1:0] : '0;

    // Latch events and apply write-one-to-clear, with the set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | evt;
    end

    // Return the addressed register while a read is strobed.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_CFG_LO: bus_rdata = cfg_q[0];
                A_CFG_HI: bus_rdata = cfg_q[1];
                A_MASK:   bus_rdata = {{PAD_W{1'b0}}, mask_q};
                A_PEND:   bus_rdata = {{PAD_W{1'b0}}, pend_q};
                A_STAT:   bus_rdata = {{PAD_W{1'b0}}, pend_q & ~mask_q};
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign pend = pend_q;
    assign mask = mask_q;

endmodule

// File: rtl/ext_irq_ctrl.sv
// Top level of the external line interrupt controller: synchronizer, trigger
// detector, register file and group merger.
// Assumes line_in is asynchronous and the bus is in the clk domain.
module ext_irq_ctrl
    import ext_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_GRP-1:0]   grp_irq
);

    logic [NUM_LINES-1:0]              line_sync;
    logic [NUM_LINES-1:0][FIELD_W-1:0] line_mode;
    logic [NUM_LINES-1:0]              det_evt;
    logic [NUM_LINES-1:0]              pend_q;
    logic [NUM_LINES-1:0]              mask_q;

    ext_irq_sync #(
        .W      (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (line_sync)
    );

    ext_irq_detect #(
        .W (NUM_LINES)
    ) u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (line_sync),
        .mode  (line_mode),
        .evt   (det_evt)
    );

    ext_irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .evt       (det_evt),
        .bus_rdata (bus_rdata),
        .line_mode (line_mode),
        .pend      (pend_q),
        .mask      (mask_q)
    );

    ext_irq_group u_group (
        .pend    (pend_q),
        .mask    (mask_q),
        .grp_irq (grp_irq)
    );

endmodule

// File: rtl/ext_irq_chk.sv
// Checker for the external line interrupt controller, bound to the top.
// Assumes it sees the detector events and the pending and mask state.
module ext_irq_chk
    import ext_irq_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [NUM_LINES-1:0] evt,
    input logic [NUM_LINES-1:0] pend,
    input logic [NUM_LINES-1:0] mask,
    input logic [NUM_GRP-1:0]   grp_irq
);

    localparam int PAD_W = DATA_W - NUM_LINES;
    localparam logic [DATA_W-1:0] HI_KEEP = cfg_keep(1);

    logic [DATA_W-1:0]  clr_w;
    logic [DATA_W-1:0]  pend_w;
    logic [NUM_GRP-1:0] grp_exp;

    // Clear vector the bus is writing this cycle.
    assign clr_w  = (bus_wr && bus_addr == A_PEND) ? bus_wdata : '0;
    assign pend_w = {{PAD_W{1'b0}}, pend};

    // Expected group requests, built line by line.
    always_comb begin
        grp_exp = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            for (int n = grp_lo(g); n <= grp_hi(g); n++) begin
                if (pend[n] && !mask[n]) grp_exp[g] = 1'b1;
            end
        end
    end

    AST_RST_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && grp_irq == '0)); // R1

    AST_W1C_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(pend_w) & ~pend_w & ~$past(clr_w)) == '0)); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(evt) & ~pend) == '0)); // R7

    AST_GRP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        grp_irq == grp_exp); // R5

    AST_STAT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_STAT) |-> bus_rdata == {{PAD_W{1'b0}}, pend & ~mask}); // R9

    AST_CFG_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_CFG_HI) |-> (bus_rdata & ~HI_KEEP) == '0); // R10

endmodule

bind ext_irq_ctrl ext_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt       (det_evt),
    .pend      (pend_q),
    .mask      (mask_q),
    .grp_irq   (grp_irq)
);

// File: tb/test_ext_irq_ctrl.sv
// Bench for the external line interrupt controller: a behavioural model is
// stepped on every clock edge and compared with the group outputs and reads.
module test_ext_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] line_in = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  grp_irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Model state
    bit [27:0] m_s1, m_s2, m_prev, m_pend, m_mask;
    bit [31:0] m_cfg [2];

    ext_irq_ctrl i_ext_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .grp_irq   (grp_irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit m_evt(input int n);
        int code;
        code = (m_cfg[n / 16] >> (((n % 16) / 2) * 4)) & 7;
        if (code == 0) return !m_s2[n];
        if (code == 1) return m_s2[n];
        if (code / 2 == 1) return !m_s2[n] && m_prev[n];
        if (code / 2 == 2) return m_s2[n] && !m_prev[n];
        return m_s2[n] != m_prev[n];
    endfunction

    function automatic logic [31:0] m_read(input int a);
        if (a == 0) return m_cfg[0];
        if (a == 1) return m_cfg[1];
        if (a == 2) return {4'h0, m_mask};
        if (a == 3) return {4'h0, m_pend};
        if (a == 4) return {4'h0, m_pend & ~m_mask};
        return 32'h0;
    endfunction

    function automatic logic [3:0] m_grp();
        bit [27:0] live;
        live = m_pend & ~m_mask;
        return {|live[27:20], |live[19:12], |live[11:4], |live[3:0]};
    endfunction

    // Step the reference model on every rising edge.
    always @(posedge clk) begin
        bit [27:0] nxt;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0;
            m_mask = 28'hFFFFFFF; m_cfg[0] = '0; m_cfg[1] = '0;
        end else begin
            nxt = m_pend;
            if (bus_wr && bus_addr == 3) nxt = nxt & ~bus_wdata[27:0];
            for (int n = 0; n < 28; n++) if (m_evt(n)) nxt[n] = 1'b1;
            if (bus_wr && bus_addr == 0) m_cfg[0] = bus_wdata & 32'h77777777;
            if (bus_wr && bus_addr == 1) m_cfg[1] = bus_wdata & 32'h00777777;
            if (bus_wr && bus_addr == 2) m_mask = bus_wdata[27:0];
            m_prev = m_s2; m_s2 = m_s1; m_s1 = line_in; m_pend = nxt;
        end
    end

    // Compare the group outputs shortly after every edge.
    always @(posedge clk) begin
        #1;
        if (!done) chk("R8 grp_irq", {28'h0, grp_irq}, {28'h0, m_grp()});
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 50000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic rd_chk(input int a, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 3'(a);
        #1;
        chk(tag, bus_rdata, m_read(a));
        bus_rd = 1'b0;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic drive(input int n, input bit v);
        @(negedge clk);
        line_in[n] = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        // R1: reset values
        rd_chk(2, "R1 mask");
        rd_chk(3, "R1 pend");
        rd_chk(0, "R1 cfg_lo");
        chk("R1 grp", {28'h0, grp_irq}, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        idle(4);
        // R3: low-level default fires on low lines
        rd_chk(3, "R3 low level");
        wr(0, 32'h44444444);
        wr(1, 32'h00444444);
        wr(3, 32'h0FFFFFFF);
        wr(2, 32'h0);
        idle(3);
        rd_chk(3, "R6 all cleared");
        // R2: latency of the synchronizer and pending register
        drive(5, 1'b1);
        rd_chk(3, "R2 early");
        rd_chk(3, "R2 early");
        rd_chk(3, "R2 set");
        rd_chk(4, "R9 status");
        // R6: clear one bit only
        drive(13, 1'b1);
        idle(4);
        wr(3, 32'h20);
        rd_chk(3, "R6 single clear");
        // R3: falling edge on lines 12/13
        wr(0, 32'h42444444);
        wr(3, 32'h2000);
        drive(13, 1'b0);
        idle(4);
        rd_chk(3, "R3 falling");
        // R3: both edges
        wr(0, 32'h46444444);
        wr(3, 32'h2000);
        drive(13, 1'b1);
        idle(4);
        rd_chk(3, "R3 both rise");
        wr(3, 32'h2000);
        drive(13, 1'b0);
        idle(4);
        rd_chk(3, "R3 both fall");
        // R7: high level on line 9, clear while still active
        wr(0, 32'h46414444);
        drive(9, 1'b1);
        idle(4);
        wr(3, 32'h200);
        rd_chk(3, "R7 set wins");
        drive(9, 1'b0);
        idle(4);
        wr(3, 32'h200);
        rd_chk(3, "R7 cleared");
        // R4: lines 26/27 share the field at bits 20..22 of offset 1
        wr(1, 32'h00144444);
        wr(3, 32'h0FFFFFFF);
        drive(27, 1'b1);
        idle(4);
        rd_chk(3, "R4 shared field");
        rd_chk(1, "R4 cfg_hi");
        // R5: masked lines still latch
        wr(2, 32'h08400000);
        drive(22, 1'b1);
        idle(4);
        rd_chk(3, "R5 masked pend");
        rd_chk(4, "R5 status");
        drive(22, 1'b0);
        drive(27, 1'b0);
        wr(3, 32'h0FFFFFFF);
        wr(2, 32'h0);
        // R8: group boundaries
        foreach (line_in[n]) begin
            if (n == 3 || n == 4 || n == 11 || n == 12 || n == 19 || n == 20) begin
                drive(n, 1'b1);
                idle(4);
                rd_chk(4, "R8 boundary");
                drive(n, 1'b0);
                idle(4);
                wr(3, 32'h0FFFFFFF);
                idle(1);
            end
        end
        // R10: spare bits and empty offsets
        wr(1, 32'hFFFFFFFF);
        rd_chk(1, "R10 cfg_hi spare");
        wr(0, 32'hFFFFFFFF);
        rd_chk(0, "R10 cfg_lo spare");
        rd_chk(5, "R10 offset 5");
        rd_chk(6, "R10 offset 6");
        rd_chk(7, "R10 offset 7");
        @(negedge clk);
        bus_addr = 3'd3;
        #1;
        chk("R10 no strobe", bus_rdata, 32'h0);
        idle(2);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule